// File: doc/BRIEF.md
# Selectable Reference Pulse Generator

The block turns a low-frequency timekeeping clock (nominally 32768 Hz) into a square reference wave on one output line. A single select input picks one of two rates. With the select low, the clock is divided by a small even factor to give a fast 50% duty wave (1024 Hz at the default settings). With the select high, a one-second tick is formed from the clock, and a seconds counter turns it into a slow wave. That wave is high for the first half of its period and low for the second half (0.1 Hz, 5 s high then 5 s low, at the default settings).

Once either kind of reset has been applied, the slow wave is forced low for a blanking interval (10 s by default). A reset can be the asynchronous power-on reset or a synchronous system-reset request. The fast wave is never blanked. When the select input changes, the newly chosen divider restarts from phase zero on that same clock edge, so the first phase of the new rate lasts its full length. The blanking timer keeps running across select changes. The output is registered.

The input clock rate, the fast division factor, the slow period in seconds and the blanking length in seconds are all parameters. Elaboration rejects illegal combinations of them.

Top module: `refpulse_gen`

## Requirements
- R1: With `sel_slow` low, `pulse_out` has a period of FAST_DIV clock edges. After the phase-zero edge (a reset edge or the edge at which fast mode was selected), it is low for FAST_DIV/2 edges and then high for FAST_DIV/2 edges, repeating.
- R2: With `sel_slow` high and blanking over, `pulse_out` has a period of SLOW_PERIOD_S*CLK_HZ edges, counted in whole seconds of CLK_HZ edges from the phase-zero edge. It is high while the seconds count is below SLOW_PERIOD_S/2 and low for the rest of the period.
- R3: In slow mode, `pulse_out` stays low until BLANK_S*CLK_HZ edges have passed since the most recent reset. The fast wave is not affected by blanking.
- R4: Both the asynchronous `rst_n` (active low) and a synchronous `sys_rst` pulse (active high, one edge) clear both dividers to phase zero, force `pulse_out` low and restart the blanking interval.
- R5: On the first edge at which `sel_slow` differs from its value at the previous edge, the selected divider restarts at phase zero. The blanking timer is not restarted by a select change.
- R6: While `rst_n` is low, `pulse_out` is 0 and the previously sampled select is taken as 0 (fast).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timekeeping clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset request, active high |
| sel_slow | input | 1 | Rate select: 0 fast wave, 1 slow wave |
| pulse_out | output | 1 | Registered square reference output |

## Verification
The bench builds the block with CLK_HZ=8, FAST_DIV=4, SLOW_PERIOD_S=4 and BLANK_S=4. With these values a whole slow period lasts 32 edges, and so does the blanking interval. Every phase of both waves, the end of blanking, and select changes falling inside and outside the blanking window can therefore be reached in a few hundred cycles. An arithmetic model in the bench predicts the output on every cycle, so each edge of every sequence is checked rather than a sample of them.

// File: rtl/refpulse_pkg.sv
package refpulse_pkg;

   typedef enum logic {
      RATE_FAST = 1'b0,
      RATE_SLOW = 1'b1
   } rate_e;

   function automatic int cnt_width(input int modulus);
      return (modulus > 1) ? $clog2(modulus) : 1;
   endfunction

   function automatic bit is_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/rp_mod_counter.sv
module rp_mod_counter
   import refpulse_pkg::*;
#(
   parameter int MOD = 32,
   localparam int W = cnt_width(MOD)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt,
   output logic         at_last
);

   localparam logic [W-1:0] LAST = W'(MOD - 1);

   if (MOD < 2) begin : g_bad_mod
      $error("rp_mod_counter: MOD must be at least 2");
   end

   assign at_last = (cnt == LAST);

   if (is_pow2(MOD)) begin : g_wrap_natural
      always_comb begin
         if (clr)     cnt_nxt = '0;
         else if (en) cnt_nxt = cnt + 1'b1;
         else         cnt_nxt = cnt;
      end
   end else begin : g_wrap_compare
      always_comb begin
         if (clr)          cnt_nxt = '0;
         else if (!en)     cnt_nxt = cnt;
         else if (at_last) cnt_nxt = '0;
         else              cnt_nxt = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/rp_blank_timer.sv
module rp_blank_timer
   import refpulse_pkg::*;
#(
   parameter int LIMIT = 327680,
   localparam int W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic blanking,
   output logic blank_nxt
);

   localparam logic [W-1:0] LIM = W'(LIMIT);

   logic [W-1:0] elapsed;
   logic [W-1:0] elapsed_nxt;

   if (LIMIT < 1) begin : g_bad_limit
      $error("rp_blank_timer: LIMIT must be at least 1");
   end

   always_comb begin
      if (clr)                elapsed_nxt = '0;
      else if (elapsed < LIM) elapsed_nxt = elapsed + 1'b1;
      else                    elapsed_nxt = elapsed;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) elapsed <= '0;
      else        elapsed <= elapsed_nxt;
   end

   assign blanking  = (elapsed < LIM);
   assign blank_nxt = (elapsed_nxt < LIM);

   assert_blank_ends_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !blanking) |=> !blanking);

   assert_blank_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> blanking);

endmodule

// File: rtl/refpulse_gen.sv
module refpulse_gen
   import refpulse_pkg::*;
#(
   parameter int CLK_HZ        = 32768,
   parameter int FAST_DIV      = 32,
   parameter int SLOW_PERIOD_S = 10,
   parameter int BLANK_S       = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_rst,
   input  logic sel_slow,
   output logic pulse_out
);

   localparam int FW        = cnt_width(FAST_DIV);
   localparam int PW        = cnt_width(CLK_HZ);
   localparam int SW        = cnt_width(SLOW_PERIOD_S);
   localparam int FHALF     = FAST_DIV / 2;
   localparam int SEC_HALF  = SLOW_PERIOD_S / 2;
   localparam int BLANK_CYC = BLANK_S * CLK_HZ;

   if (FAST_DIV < 2 || (FAST_DIV % 2) != 0) begin : g_bad_fast
      $error("refpulse_gen: FAST_DIV must be even and at least 2");
   end
   if (SLOW_PERIOD_S < 2 || (SLOW_PERIOD_S % 2) != 0) begin : g_bad_slow
      $error("refpulse_gen: SLOW_PERIOD_S must be even and at least 2");
   end
   if (CLK_HZ < 2) begin : g_bad_clk
      $error("refpulse_gen: CLK_HZ must be at least 2");
   end
   if (BLANK_S < 1) begin : g_bad_blank
      $error("refpulse_gen: BLANK_S must be at least 1");
   end

   rate_e         rate_q;
   rate_e         rate_d;
   logic          restart;
   logic          phase_clr;

   logic [FW-1:0] fast_cnt, fast_nxt;
   logic          fast_last;
   logic [PW-1:0] pre_cnt, pre_nxt;
   logic          pre_last;
   logic [SW-1:0] sec_cnt, sec_nxt;
   logic          sec_last;
   logic          blanking, blank_nxt;
   logic          out_d;

   assign rate_d    = sel_slow ? RATE_SLOW : RATE_FAST;
   assign restart   = (rate_d != rate_q);
   assign phase_clr = sys_rst | restart;

   rp_mod_counter #(.MOD(FAST_DIV)) u_fast (
      .clk(clk), .rst_n(rst_n), .clr(phase_clr), .en(1'b1),
      .cnt(fast_cnt), .cnt_nxt(fast_nxt), .at_last(fast_last)
   );

   rp_mod_counter #(.MOD(CLK_HZ)) u_prescale (
      .clk(clk), .rst_n(rst_n), .clr(phase_clr), .en(1'b1),
      .cnt(pre_cnt), .cnt_nxt(pre_nxt), .at_last(pre_last)
   );

   rp_mod_counter #(.MOD(SLOW_PERIOD_S)) u_seconds (
      .clk(clk), .rst_n(rst_n), .clr(phase_clr), .en(pre_last),
      .cnt(sec_cnt), .cnt_nxt(sec_nxt), .at_last(sec_last)
   );

   rp_blank_timer #(.LIMIT(BLANK_CYC)) u_blank (
      .clk(clk), .rst_n(rst_n), .clr(sys_rst),
      .blanking(blanking), .blank_nxt(blank_nxt)
   );

   always_comb begin
      if (sys_rst)                out_d = 1'b0;
      else if (rate_d == RATE_SLOW) out_d = !blank_nxt && (sec_nxt < SW'(SEC_HALF));
      else                        out_d = (fast_nxt >= FW'(FHALF));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q    <= RATE_FAST;
         pulse_out <= 1'b0;
      end else begin
         rate_q    <= rate_d;
         pulse_out <= out_d;
      end
   end

   assert_fast_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_rst && !sel_slow && rate_q == RATE_FAST && fast_cnt == FW'(FHALF - 1))
      |=> pulse_out);

   assert_fast_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_rst && !sel_slow && rate_q == RATE_FAST && fast_last) |=> !pulse_out);

   assert_slow_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == RATE_SLOW && !blanking) |-> (pulse_out == (sec_cnt < SW'(SEC_HALF))));

   assert_slow_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase_clr && sec_last && pre_last) |=> (sec_cnt == '0));

   assert_blank_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == RATE_SLOW && blanking) |-> !pulse_out);

   assert_sysrst_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> (!pulse_out && blanking));

   assert_restart_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_rst && restart) |-> (pre_nxt == '0 && sec_nxt == '0 && fast_nxt == '0));

   assert_restart_keeps_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_rst && restart && !blanking) |=> !blanking);

endmodule

// File: tb/refpulse_gen_test.sv
`timescale 1ns/1ps
module refpulse_gen_test;

   localparam int CLK_HZ = 8;
   localparam int FDIV   = 4;
   localparam int SPER   = 4;
   localparam int BLNK   = 4;
   localparam int SCYC   = SPER * CLK_HZ;
   localparam int BCYC   = BLNK * CLK_HZ;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sys_rst = 1'b0;
   logic sel_slow = 1'b0;
   logic pulse_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state: edges since phase zero, edges since reset, mode
   int  m_e = 0;
   int  m_b = 0;
   bit  m_slow = 1'b0;
   int  m_ev = 0;   // 0 none, 1 async reset, 2 sys reset, 3 select change

   always #2.5 clk = ~clk;

   refpulse_gen #(.CLK_HZ(CLK_HZ), .FAST_DIV(FDIV), .SLOW_PERIOD_S(SPER),
                  .BLANK_S(BLNK)) uut (
      .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .sel_slow(sel_slow),
      .pulse_out(pulse_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: pulse_out=%b expected=%b (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_e = 0; m_b = 0; m_slow = 1'b0; m_ev = 1;
      end else if (sys_rst) begin
         m_e = 0; m_b = 0; m_slow = sel_slow; m_ev = 2;
      end else begin
         if (m_b < BCYC) m_b++;
         if (sel_slow != m_slow) begin
            m_e = 0; m_slow = sel_slow; m_ev = 3;
         end else begin
            m_e++; m_ev = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk("R6", pulse_out, 1'b0);
         end else begin
            logic  exp;
            string tag;
            if (m_slow) begin
               exp = (m_b >= BCYC) && ((m_e % SCYC) < (SCYC / 2));
               tag = (m_b < BCYC) ? "R3" : "R2";
            end else begin
               exp = ((m_e % FDIV) >= (FDIV / 2));
               tag = "R1";
            end
            if (m_ev == 2 || m_ev == 1) tag = "R4";
            if (m_ev == 3) tag = "R5";
            chk(tag, pulse_out, exp);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      // fast wave from power-on
      step(40);
      // slow wave after power-on blanking window has already passed
      sel_slow = 1'b1;
      step(80);
      // system reset while slow: blanking restarts
      sys_rst = 1'b1; step(1); sys_rst = 1'b0;
      step(10);
      // select changes inside blanking: timer must not restart
      sel_slow = 1'b0; step(5);
      sel_slow = 1'b1; step(70);
      // mid-phase switches
      sel_slow = 1'b0; step(3);
      sel_slow = 1'b1; step(11);
      sel_slow = 1'b0; step(1);
      sel_slow = 1'b1; step(1);
      sel_slow = 1'b0; step(9);
      sel_slow = 1'b1; step(45);
      // system reset in fast mode
      sel_slow = 1'b0; step(6);
      sys_rst = 1'b1; step(1); sys_rst = 1'b0;
      step(20);
      // system reset together with a select change
      sel_slow = 1'b1; sys_rst = 1'b1; step(1); sys_rst = 1'b0;
      step(70);
      // asynchronous reset in the middle of a slow run
      #1 rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      sel_slow = 1'b1;
      step(80);
      sel_slow = 1'b0;
      step(12);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end (expected completion)");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule